// File: doc/BRIEF.md
# Five-Bit Word Serializer

The block takes a parallel word, five bits wide by default, and sends it out one bit per rising edge of the bit clock, least significant bit first. An upstream source presents the word together with a valid flag. The serializer looks at that flag only at a word boundary, meaning when no word is being sent or when the last bit of the current word is on the line. When the flag is high there, the word is copied into an internal shift register and its bit 0 appears on the serial output after that same clock edge.

Two flags go with the serial bit. `sending` is high for every cycle that a valid data bit is on the line. `word_done` is high for exactly the cycle that carries the final bit of a word. The source can use `word_done` as a request for the next word. If the source holds valid high in that cycle, the next word follows without an idle bit. The serial bit and both flags come straight from flip-flops, so a receiver never sees a combinational glitch on them.

Top module: `ser5_serializer`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `ser_bit`, `sending` and `word_done` to 0 after that edge, even when a word is in flight.
- R2: If `word_valid` is low at a word boundary, the cycle that follows has `sending` = 0, `ser_bit` = 0 and `word_done` = 0.
- R3: If `word_valid` is high at an edge where the block is idle, the cycle after that edge has `sending` = 1 and `ser_bit` equal to bit 0 of `par_word` as sampled at that edge.
- R4: In the k-th cycle after the start edge (k = 0 .. WORD_W-1), `ser_bit` equals bit k of the captured word, so the least significant bit goes first.
- R5: `sending` stays high for all WORD_W bit cycles of a word.
- R6: `word_done` is 1 in the cycle that carries bit WORD_W-1 and 0 in every other cycle.
- R7: `word_valid` has no effect while a word is in the middle of being sent (cycles k = 0 .. WORD_W-2).
- R8: A change on `par_word` after the start edge does not change the bits of the word being sent.
- R9: If `word_valid` is high in the cycle where `word_done` is 1, the next cycle carries bit 0 of the new word, and `sending` stays high with no gap.
- R10: If `word_valid` is low in the cycle where `word_done` is 1, `sending` falls to 0 in the next cycle.
- R11: The outputs change only at rising clock edges. A change on `par_word` or `word_valid` between edges leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| par_word | input | WORD_W | Parallel word to be sent |
| word_valid | input | 1 | Offer of `par_word`; sampled only at word boundaries |
| ser_bit | output | 1 | Serial data bit, least significant bit first; 0 when idle |
| sending | output | 1 | High while a valid data bit is on `ser_bit` |
| word_done | output | 1 | High in the cycle that carries the last bit of a word |

## Verification
The bench sends every one of the 32 five-bit words back to back, so each word boundary is a gapless handover. A design that inserted an idle cycle, or sampled valid one cycle late, would shift every later word by a bit. While a word is in flight, the bench scrambles the parallel input and toggles valid. A design without a captured copy of the word would send corrupted bits, and one that obeyed valid mid-word would restart the word. It also checks that the line goes idle when valid drops at the last bit, that a reset in mid-word clears the outputs, and that inputs changed between edges do not reach the outputs. A decoded, unregistered flag would fail this last check.

// File: rtl/ser5_pkg.sv
package ser5_pkg;

  // Position that follows cur within a word of w bits; wraps to 0 after w-1.
  function automatic int unsigned next_pos(int unsigned cur, int unsigned w);
    return (cur + 1 >= w) ? 0 : cur + 1;
  endfunction

  // Index of the final bit of a word of w bits.
  function automatic int unsigned final_pos(int unsigned w);
    return w - 1;
  endfunction

endpackage

// File: rtl/ser5_index_ctr.sv
module ser5_index_ctr #(
  parameter int WORD_W = 5,
  parameter int IDX_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [IDX_W-1:0] idx_q,
  output logic             at_boundary,
  output logic             at_last
);
  import ser5_pkg::*;

  assign at_boundary = (idx_q == '0);
  assign at_last     = (idx_q == IDX_W'(final_pos(WORD_W)));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (advance) begin
      idx_q <= IDX_W'(next_pos(int'(idx_q), WORD_W));
    end
  end
endmodule

// File: rtl/ser5_shift_path.sv
module ser5_shift_path #(
  parameter int WORD_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [WORD_W-1:0] din,
  output logic              sdo_q
);
  logic [WORD_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      sdo_q  <= 1'b0;
    end else if (load) begin
      sdo_q  <= din[0];
      hold_q <= din >> 1;
    end else if (shift) begin
      sdo_q  <= hold_q[0];
      hold_q <= hold_q >> 1;
    end else begin
      sdo_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/ser5_ctl.sv
module ser5_ctl (
  input  logic clk,
  input  logic rst,
  input  logic at_boundary,
  input  logic at_last,
  input  logic valid_in,
  output logic start,
  output logic advance,
  output logic busy_q,
  output logic done_q
);
  assign start   = at_boundary & valid_in;
  assign advance = start | ~at_boundary;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= advance;
      done_q <= advance & at_last;
    end
  end
endmodule

// File: rtl/ser5_serializer.sv
module ser5_serializer #(
  parameter int WORD_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] par_word,
  input  logic              word_valid,
  output logic              ser_bit,
  output logic              sending,
  output logic              word_done
);
  localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic [IDX_W-1:0] idx_q;
  logic             at_boundary;
  logic             at_last;
  logic             word_start;
  logic             advance;
  logic             mid_shift;

  assign mid_shift = advance & ~word_start;

  ser5_ctl u_ctl (
    .clk         (clk),
    .rst         (rst),
    .at_boundary (at_boundary),
    .at_last     (at_last),
    .valid_in    (word_valid),
    .start       (word_start),
    .advance     (advance),
    .busy_q      (sending),
    .done_q      (word_done)
  );

  ser5_index_ctr #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_idx (
    .clk         (clk),
    .rst         (rst),
    .advance     (advance),
    .idx_q       (idx_q),
    .at_boundary (at_boundary),
    .at_last     (at_last)
  );

  ser5_shift_path #(.WORD_W(WORD_W)) u_path (
    .clk   (clk),
    .rst   (rst),
    .load  (word_start),
    .shift (mid_shift),
    .din   (par_word),
    .sdo_q (ser_bit)
  );
endmodule

// File: rtl/ser5_serializer_chk.sv
module ser5_serializer_chk (
  input logic clk,
  input logic rst,
  input logic first_bit,
  input logic word_valid,
  input logic ser_bit,
  input logic sending,
  input logic word_done,
  input logic word_start,
  input logic at_boundary
);
  // R2: idle boundary leaves the line quiet
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (at_boundary && !word_valid) |=> (!sending && !ser_bit && !word_done));

  // R3: a start puts bit 0 of the sampled word on the line
  p_start_bit0_r3: assert property (@(posedge clk) disable iff (rst)
    word_start |=> (sending && (ser_bit == $past(first_bit))));

  // R6: a completion mark only occurs on a data cycle
  p_done_in_word_r6: assert property (@(posedge clk) disable iff (rst)
    word_done |-> sending);

  // R7: mid-word the line stays busy whatever valid does
  p_mid_word_busy_r7: assert property (@(posedge clk) disable iff (rst)
    !at_boundary |=> sending);

  // R9: valid during the last bit gives a gapless handover
  p_back_to_back_r9: assert property (@(posedge clk) disable iff (rst)
    (word_done && word_valid) |=> (sending && !word_done));
endmodule

bind ser5_serializer ser5_serializer_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .first_bit   (par_word[0]),
  .word_valid  (word_valid),
  .ser_bit     (ser_bit),
  .sending     (sending),
  .word_done   (word_done),
  .word_start  (word_start),
  .at_boundary (at_boundary)
);

// File: tb/ser5_serializer_tb.sv
`timescale 1ns/1ps
module ser5_serializer_tb;
  localparam int W = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] par_word = '0;
  logic         word_valid = 1'b0;
  logic         ser_bit, sending, word_done;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  ser5_serializer #(.WORD_W(W)) u_dut (
    .clk(clk), .rst(rst), .par_word(par_word), .word_valid(word_valid),
    .ser_bit(ser_bit), .sending(sending), .word_done(word_done)
  );

  // Compare {sending, word_done, ser_bit} with the expected triple.
  task automatic chk(input string req, input logic [2:0] exp);
    logic [2:0] got;
    got = {sending, word_done, ser_bit};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got {sending,done,bit}=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic bit_of(int w, int k);
    return logic'((w >> k) & 1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R5: run did not finish, got hang expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2:0] snap;
    repeat (3) @(negedge clk);
    chk("R1 reset state", 3'b000);
    rst = 1'b0;

    // Idle with valid low: line quiet for several cycles (R2)
    for (int c = 0; c < 3; c++) begin
      par_word = W'(c * 7 + 3);
      @(negedge clk);
      chk("R2 idle", 3'b000);
    end

    // All 32 words back to back, inputs scrambled mid-word
    par_word   = W'(0);
    word_valid = 1'b1;
    for (int i = 0; i < 32; i++) begin
      for (int k = 0; k < W; k++) begin
        @(negedge clk);
        if (k == 0)
          chk(i == 0 ? "R3 first bit" : "R9 gapless next word",
              {1'b1, 1'b0, bit_of(i, 0)});
        else if (k == W - 1)
          chk("R6 last bit with done", {1'b1, 1'b1, bit_of(i, k)});
        else
          chk("R4 R5 R7 R8 mid bit", {1'b1, 1'b0, bit_of(i, k)});
        if (k < W - 1) begin
          word_valid = logic'(k & 1);
          par_word   = ~W'(i);
        end else if (i < 31) begin
          word_valid = 1'b1;
          par_word   = W'(i + 1);
        end else begin
          word_valid = 1'b0;
          par_word   = W'(21);
        end
      end
    end
    @(negedge clk);
    chk("R10 falls after last word", 3'b000);
    @(negedge clk);
    chk("R2 stays idle", 3'b000);

    // Single word after a gap, then valid low in done cycle
    par_word = W'(5'b10110); word_valid = 1'b1;
    for (int k = 0; k < W; k++) begin
      @(negedge clk);
      chk("R4 single word", {1'b1, logic'(k == W - 1), bit_of(5'b10110, k)});
      word_valid = 1'b0;
      par_word   = W'(5'b01001);
    end
    @(negedge clk);
    chk("R10 idle after single", 3'b000);

    // Inputs changing between edges do not move outputs (R11)
    snap = {sending, word_done, ser_bit};
    #0.5 par_word = W'(31); word_valid = 1'b1;
    #0.5 chk("R11 idle glitch-free", snap);
    @(negedge clk);
    chk("R3 start from idle", {1'b1, 1'b0, 1'b1});
    snap = {sending, word_done, ser_bit};
    #0.5 par_word = W'(0); word_valid = 1'b0;
    #0.5 chk("R11 mid-word glitch-free", snap);

    // Reset in mid-word (R1)
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset mid-word", 3'b000);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 idle after reset", 3'b000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule